// File: doc/BRIEF.md
# Fractional-Second Real-Time Clock with Field Alarm

This block keeps wall time from a 32.768 kHz clock. A prescaler turns every 128 input cycles into one tick of 1/256 second. Each tick advances a chain of binary counters: a fraction field (0 to 255), seconds, minutes, hours, and a 16-bit count of elapsed days. The day count is a plain number. Turning it into a calendar date is left to software.

An alarm comparator holds four user values, one each for the fraction, seconds, minutes and hours. Each of the four has its own compare enable. On a tick, if every enabled field equals the time just reached, a sticky alarm flag is set. The flag drives the interrupt output only while the interrupt enable is set. With no field enabled, the flag sets on every tick (256 times per second). Enabling the fraction compare alone gives one event per second. Each coarser field added divides the rate again: one per minute, one per hour, one per day.

All time values, alarm values and control bits sit behind one synchronous write port and one combinational read port.

Top module: `frac_rtc`

## Requirements
- R1: After reset, every time counter, alarm value and control bit reads 0, and `alarm_irq` is low.
- R2: While the run bit (control bit 0) is 1, the fraction field advances by one every 128 clock cycles.
- R3: While the run bit is 0, no time field changes unless it is written, and the prescaler holds its phase.
- R4: The fraction field wraps from 255 to 0, and that wrap advances the seconds field.
- R5: Seconds and minutes wrap from 59 to 0, and each wrap carries into the next field. Hours wrap from 23 to 0, and that wrap increments the day count.
- R6: The day count wraps from 0xFFFF to 0.
- R7: With all four match enables (control bits 6:3) clear, every tick sets the alarm flag (control bit 2).
- R8: Match enables are ordered fraction = bit 3, seconds = bit 4, minutes = bit 5, hours = bit 6. On a tick, the flag is set only if every enabled field of the newly reached time equals its alarm value.
- R9: The flag stays set until a control write with bit 2 = 0 clears it. A control write with bit 2 = 1 never sets the flag. If a match and a clearing write fall on the same edge, the flag ends up set.
- R10: `alarm_irq` is high exactly when both the flag and the interrupt enable (control bit 1) are 1.
- R11: A write to a time register loads that field on the same edge, even if a tick arrives on that edge. That tick then advances no field and cannot set the flag.
- R12: The register addresses are:
  - 0: fraction, 8 bits.
  - 1: seconds, 6 bits.
  - 2: minutes, 6 bits.
  - 3: hours, 5 bits.
  - 4: days, 16 bits.
  - 5 to 8: alarm fraction, seconds, minutes and hours, 8 bits each.
  - 9: control.

  Reads are zero-extended to 16 bits, and writes keep only the low bits of each field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
Two pairs of events can land on the same edge:
- a software write to a time field and a prescaler tick;
- a flag-clearing control write and an alarm match.

The bench tracks the prescaler phase in its own model. It places each colliding write on the exact edge where the tick falls. It then judges the outcome by reading the field and the flag in the next half cycle: the loaded value must be present unadvanced, and the flag must survive the clear.

// File: rtl/frac_rtc_pkg.sv
package frac_rtc_pkg;
  localparam int SUB_W    = 8;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HR_W     = 5;
  localparam int DAY_W    = 16;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int ALM_W    = 8;
  localparam int NFIELD   = 4;
  localparam int NTIME    = 5;
  localparam int SEC_LAST = 59;
  localparam int MIN_LAST = 59;
  localparam int HR_LAST  = 23;

  localparam logic [ADDR_W-1:0] A_SUB  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_HR   = 4'd3;
  localparam logic [ADDR_W-1:0] A_DAY  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ALM0 = 4'd5;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd9;

  localparam int C_RUN  = 0;
  localparam int C_IE   = 1;
  localparam int C_FLAG = 2;
  localparam int C_MEN  = 3;

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
    logic [SUB_W-1:0] sub;
  } rtc_time_t;
endpackage

// File: rtl/frac_rtc_prescale.sv
module frac_rtc_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frac_rtc_count.sv
module frac_rtc_count
  import frac_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NTIME-1:0]  ld,
  input  logic [DATA_W-1:0] ld_data,
  output rtc_time_t         now,
  output rtc_time_t         adv
);
  rtc_time_t now_d;
  logic c_sub, c_sec, c_min, c_hr, upd;

  // Carry chain for one tick
  always_comb begin
    c_sub = (now.sub == '1);
    c_sec = c_sub && (now.sec == SEC_W'(SEC_LAST));
    c_min = c_sec && (now.min == MIN_W'(MIN_LAST));
    c_hr  = c_min && (now.hr  == HR_W'(HR_LAST));
    adv.sub = now.sub + 1'b1;
    adv.sec = c_sub ? (c_sec ? '0 : now.sec + 1'b1) : now.sec;
    adv.min = c_sec ? (c_min ? '0 : now.min + 1'b1) : now.min;
    adv.hr  = c_min ? (c_hr  ? '0 : now.hr  + 1'b1) : now.hr;
    adv.day = c_hr  ? now.day + 1'b1 : now.day;
  end

  // A load beats a tick on the same edge
  always_comb begin
    upd   = tick || (|ld);
    now_d = now;
    if (|ld) begin
      if (ld[0]) now_d.sub = ld_data[SUB_W-1:0];
      if (ld[1]) now_d.sec = ld_data[SEC_W-1:0];
      if (ld[2]) now_d.min = ld_data[MIN_W-1:0];
      if (ld[3]) now_d.hr  = ld_data[HR_W-1:0];
      if (ld[4]) now_d.day = ld_data[DAY_W-1:0];
    end else if (tick) begin
      now_d = adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   now <= '0;
    else if (upd) now <= now_d;
  end
endmodule

// File: rtl/frac_rtc_alarm.sv
module frac_rtc_alarm
  import frac_rtc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         eval,
  input  rtc_time_t                    adv,
  input  logic [NFIELD-1:0]            alm_we,
  input  logic [ALM_W-1:0]             alm_wdata,
  input  logic [NFIELD-1:0]            men,
  input  logic                         clr,
  output logic [NFIELD-1:0][ALM_W-1:0] alm,
  output logic                         flag
);
  logic [NFIELD-1:0][ALM_W-1:0] live;
  logic [NFIELD-1:0]            fld_ok;
  logic                         hit, flag_d;

  always_comb begin
    live[0] = ALM_W'(adv.sub);
    live[1] = ALM_W'(adv.sec);
    live[2] = ALM_W'(adv.min);
    live[3] = ALM_W'(adv.hr);
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         alm[i] <= '0;
      else if (alm_we[i]) alm[i] <= alm_wdata;
    end
    assign fld_ok[i] = !men[i] || (live[i] == alm[i]);
  end

  // A match outranks a clear on the same edge
  always_comb begin
    hit    = eval && (&fld_ok);
    flag_d = hit || (flag && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/frac_rtc.sv
module frac_rtc
  import frac_rtc_pkg::*;
#(
  parameter int TICK_DIV = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [3:0]        rd_addr,
  output logic [15:0]       rd_data,
  output logic              alarm_irq
);
  logic                         rst_s1, rst_sn;
  logic                         run, ie, flag, tick, ctrl_we, time_wr;
  logic [NFIELD-1:0]            men;
  logic [NTIME-1:0]             ld;
  logic [NFIELD-1:0]            alm_we;
  logic [NFIELD-1:0][ALM_W-1:0] alm;
  rtc_time_t                    now, adv;

  // Reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  // Address decode for writes
  always_comb begin
    for (int i = 0; i < NTIME; i++)
      ld[i] = wr_en && (wr_addr == ADDR_W'(i));
    for (int j = 0; j < NFIELD; j++)
      alm_we[j] = wr_en && (wr_addr == A_ALM0 + ADDR_W'(j));
    time_wr = |ld;
    ctrl_we = wr_en && (wr_addr == A_CTRL);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run <= 1'b0;
      ie  <= 1'b0;
      men <= '0;
    end else if (ctrl_we) begin
      run <= wr_data[C_RUN];
      ie  <= wr_data[C_IE];
      men <= wr_data[C_MEN +: NFIELD];
    end
  end

  frac_rtc_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_sn), .run(run), .tick(tick)
  );

  frac_rtc_count u_cnt (
    .clk(clk), .rst_n(rst_sn), .tick(tick), .ld(ld), .ld_data(wr_data),
    .now(now), .adv(adv)
  );

  frac_rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_sn), .eval(tick && !time_wr), .adv(adv),
    .alm_we(alm_we), .alm_wdata(wr_data[ALM_W-1:0]), .men(men),
    .clr(ctrl_we && !wr_data[C_FLAG]), .alm(alm), .flag(flag)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_SUB:   rd_data = DATA_W'(now.sub);
      A_SEC:   rd_data = DATA_W'(now.sec);
      A_MIN:   rd_data = DATA_W'(now.min);
      A_HR:    rd_data = DATA_W'(now.hr);
      A_DAY:   rd_data = DATA_W'(now.day);
      4'd5:    rd_data = DATA_W'(alm[0]);
      4'd6:    rd_data = DATA_W'(alm[1]);
      4'd7:    rd_data = DATA_W'(alm[2]);
      4'd8:    rd_data = DATA_W'(alm[3]);
      A_CTRL:  rd_data = DATA_W'({men, flag, ie, run});
      default: rd_data = '0;
    endcase
    alarm_irq = flag && ie;
  end
endmodule

// File: rtl/frac_rtc_checker.sv
module frac_rtc_checker
  import frac_rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_sn,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic [15:0]       wr_data,
  input logic              run,
  input logic              ie,
  input logic              flag,
  input logic              tick,
  input logic              time_wr,
  input logic [NFIELD-1:0] men,
  input rtc_time_t         now,
  input logic              alarm_irq
);
  // R2: one tick advances the fraction by one
  assert_sub_step_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && !time_wr && now.sub != 8'hFF) |=> (now.sub == $past(now.sub) + 8'd1));

  // R3: stopped and unwritten time stays put
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!run && !wr_en) |=> $stable(now));

  // R4: fraction wrap lands on zero
  assert_sub_wrap_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && !time_wr && now.sub == 8'hFF) |=> (now.sub == 8'h00));

  // R7: no enables means every tick flags
  assert_every_tick_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && !time_wr && men == '0) |=> flag);

  // R9: flag only falls on a clearing control write
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (flag && !(wr_en && wr_addr == A_CTRL && !wr_data[C_FLAG])) |=> flag);

  // R10: no request without the enable
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    alarm_irq |-> (ie && flag));

  // R11: a fraction write is loaded verbatim
  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && wr_addr == A_SUB) |=> (now.sub == $past(wr_data[7:0])));
endmodule

bind frac_rtc frac_rtc_checker u_chk (
  .clk(clk), .rst_sn(rst_sn), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .run(run), .ie(ie), .flag(flag), .tick(tick),
  .time_wr(time_wr), .men(men), .now(now), .alarm_irq(alarm_irq)
);

// File: tb/frac_rtc_bench.sv
`timescale 1ns/1ps
module frac_rtc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        alarm_irq;

  int    n_vec = 0, n_bad = 0;
  bit    done = 1'b0, sweep = 1'b0, comparing = 1'b0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_sub, m_sec, m_min, m_hr, m_day, m_pcnt, m_men;
  int m_alm[4];
  bit m_run, m_ie, m_flag;

  always #5 clk = ~clk;

  frac_rtc u_frac_rtc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_irq(alarm_irq)
  );

  always @(posedge clk) begin
    bit tk, hit, tw;
    if (!rst_n) begin
      m_sub = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_pcnt = 0;
      m_men = 0; m_run = 0; m_ie = 0; m_flag = 0;
      foreach (m_alm[k]) m_alm[k] = 0;
    end else begin
      tk  = m_run && (m_pcnt == 127);
      hit = 0;
      if (m_run) m_pcnt = tk ? 0 : m_pcnt + 1;
      tw = wr_en && (wr_addr <= 4);
      if (tw) begin
        case (wr_addr)
          0: m_sub = wr_data & 8'hFF;
          1: m_sec = wr_data & 6'h3F;
          2: m_min = wr_data & 6'h3F;
          3: m_hr  = wr_data & 5'h1F;
          default: m_day = wr_data;
        endcase
      end else if (tk) begin
        m_sub = (m_sub + 1) % 256;
        if (m_sub == 0) begin
          m_sec = (m_sec == 59) ? 0 : m_sec + 1;
          if (m_sec == 0) begin
            m_min = (m_min == 59) ? 0 : m_min + 1;
            if (m_min == 0) begin
              m_hr = (m_hr == 23) ? 0 : m_hr + 1;
              if (m_hr == 0) m_day = (m_day + 1) % 65536;
            end
          end
        end
        hit = (!m_men[0] || m_sub == m_alm[0]) && (!m_men[1] || m_sec == m_alm[1]) &&
              (!m_men[2] || m_min == m_alm[2]) && (!m_men[3] || m_hr == m_alm[3]);
      end
      if (hit) m_flag = 1;
      else if (wr_en && wr_addr == 9 && !wr_data[2]) m_flag = 0;
      if (wr_en && wr_addr == 9) begin
        m_run = wr_data[0]; m_ie = wr_data[1]; m_men = (wr_data >> 3) & 4'hF;
      end
      if (wr_en && wr_addr >= 5 && wr_addr <= 8) m_alm[wr_addr-5] = wr_data & 8'hFF;
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_sub;  1: return m_sec;  2: return m_min;  3: return m_hr;
      4: return m_day;  5: return m_alm[0]; 6: return m_alm[1];
      7: return m_alm[2]; 8: return m_alm[3];
      9: return (m_men << 3) | (m_flag << 2) | (m_ie << 1) | m_run;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int got, int expv);
    n_vec++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, expv, $time);
    end
  endtask

  // Clock-by-clock comparison, half a cycle after each edge
  always @(negedge clk) if (comparing) begin
    chk({cur_req, " read"}, rd_data, exp_rd(rd_addr));
    chk({cur_req, " irq"}, alarm_irq, m_flag && m_ie);
  end

  always @(posedge clk) if (sweep) rd_addr <= (rd_addr == 4'd9) ? 4'd0 : rd_addr + 4'd1;

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic to_pre_tick();
    do begin @(posedge clk); #2; end while (!(m_run && m_pcnt == 127));
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(5);
    comparing = 1'b1;
    // R1: everything zero after reset
    cur_req = "R1"; sweep = 1'b1; cyc(12); sweep = 1'b0;
    // R2: fraction counting, flag sets every tick with no enables (R7)
    cur_req = "R2"; rd_addr = 4'd0; wr(9, 16'h0001); cyc(600);
    // R3: stop and hold
    cur_req = "R3"; wr(9, 16'h0000); cyc(300);
    @(negedge clk); chk("R3 hold", rd_data, exp_rd(0)); @(posedge clk); #2;
    // R4 R5 R6: full carry chain
    cur_req = "R6";
    wr(0, 255); wr(1, 59); wr(2, 59); wr(3, 23); wr(4, 16'hFFFF);
    wr(9, 16'h0001); sweep = 1'b1; cyc(400); sweep = 1'b0;
    rd_addr = 4'd4; @(negedge clk); chk("R6 day wrap", rd_data, 0);
    rd_addr = 4'd1; @(negedge clk); chk("R4 R5 seconds", rd_data, 0);
    @(posedge clk); #2;
    // R7 R10: every tick with interrupt enabled
    cur_req = "R10"; rd_addr = 4'd9; wr(9, 16'h0003); cyc(500);
    @(negedge clk); chk("R7 flag", rd_data[2], 1); chk("R10 irq", alarm_irq, 1);
    @(posedge clk); #2;
    // R8: fraction-only match
    cur_req = "R8"; wr(0, 16'h30); wr(5, 16'h40); wr(9, 16'h000B); cyc(2000);
    @(negedge clk); chk("R8 match", rd_data[2], 1); @(posedge clk); #2;
    // R8: enabled seconds field mismatching blocks the flag
    wr(6, 5); wr(0, 16'h3E); wr(9, 16'h001B); cyc(600);
    @(negedge clk); chk("R8 mismatch", rd_data[2], 0); @(posedge clk); #2;
    // R11: time write on the tick edge
    cur_req = "R11"; wr(9, 16'h0003); rd_addr = 4'd0;
    to_pre_tick(); wr(0, 16'h10);
    @(negedge clk); chk("R11 load wins", rd_data, 16'h10); @(posedge clk); #2;
    // R9: set-only write while stopped, then collision
    cur_req = "R9"; rd_addr = 4'd9; wr(9, 16'h0002); wr(9, 16'h0006);
    @(negedge clk); chk("R9 no set by write", rd_data[2], 0); @(posedge clk); #2;
    wr(9, 16'h0003); cyc(300);
    to_pre_tick(); wr(9, 16'h0003);
    @(negedge clk); chk("R9 match beats clear", rd_data[2], 1); @(posedge clk); #2;
    wr(9, 16'h0003);
    @(negedge clk); chk("R9 cleared", rd_data[2], 0); chk("R10 irq low", alarm_irq, 0);
    @(posedge clk); #2;
    // R12: map sweep after mixed writes
    cur_req = "R12"; wr(7, 16'h1A5); wr(8, 17); wr(3, 16'h3F);
    sweep = 1'b1; cyc(30); sweep = 1'b0;
    comparing = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #1900000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule